// File: doc/BRIEF.md
# Requester-Keyed DMA Address Translation Walker

This block turns a device's DMA access, given as a 16-bit requester ID and an I/O virtual address, into a physical address. It does this in two phases. First it looks up the device: the requester's bus number picks an entry in a root table, and its device/function number picks an entry in the context table that root entry points to. Then it walks a three-level page table that the context entry names, covering a 39-bit I/O address space. Each walk ends either with a physical address or with a fault code that says which stage refused the access.

All table reads go through one 64-bit memory read port with a request handshake and a response strobe. The walker works on one request at a time. A new request is not accepted until the result of the current one has been taken. A configuration input supplies the page-aligned base of the root table. The result carries the domain number and the fault-suppression hint from the context entry, so a downstream fault recorder can use them.

Top module: `dma_xlate_walker`

## Requirements
- R1: The root entry is read at the 4 KiB page of `cfg_root_base` (its low 12 bits are ignored) plus 16 times the bus number (requester ID bits 15:8). If bit 0 of that word is clear, the walk ends with code 1 at level 0.
- R2: The context entry's lower word is read at the root entry's bits 63:12 (as a page address) plus 16 times the device/function number (requester ID bits 7:0). Its upper word is read 8 bytes later. If bit 0 of the lower word is clear, the walk ends with code 2 at level 0 and the upper word is not read.
- R3: The translation type in context lower-word bits 3:2 must be 0 (multi-level) and the width code in upper-word bits 2:0 must be 1 (39-bit, three levels). Any other value ends the walk with code 5, and no page-table word is read.
- R4: Page-table words are read at the current table page plus 8 times a 9-bit index: IOVA bits 38:30 at level 3, 29:21 at level 2 and 20:12 at level 1. A request makes exactly 0, 1, 2 or 3 set-up reads plus one read per level visited. A memory request stays asserted with a stable address until it is accepted.
- R5: A page-table word whose bits 1:0 (read/write permission) are both zero ends the walk with code 3, reported at the level where it was found (3, 2 or 1).
- R6: A valid level-1 word gives code 0 at level 1, with physical address {word[63:12], IOVA[11:0]}.
- R7: A valid word with bit 7 set at level 2 or level 3 ends the walk as a large mapping: {word[63:21], IOVA[20:0]} at level 2 and {word[63:30], IOVA[29:0]} at level 3. Otherwise bits 63:12 of a non-leaf word give the next table page.
- R8: A request with any IOVA bit 63:39 set ends with code 4 at level 0, and no memory read is made.
- R9: `req_ready` is high only while idle. It stays low from acceptance until the response handshake completes. While `resp_valid` is high and `resp_ready` low, every response field holds its value.
- R10: `resp_domain` carries context upper-word bits 23:8 for codes 0, 3 and 5, and zero for codes 1, 2 and 4.
- R11: `resp_quiet` carries context lower-word bit 1 for codes 3 and 5, and is zero for every other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_root_base | input | 64 | Root table address (page-aligned use) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_rid | input | 16 | Requester ID (bus in 15:8, device/function in 7:0) |
| req_iova | input | 64 | I/O virtual address to translate |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 64 | Byte address of the 64-bit word to read |
| mem_rsp_valid | input | 1 | Read data valid (one per accepted request) |
| mem_rsp_data | input | 64 | Read data |
| resp_valid | output | 1 | Translation result valid |
| resp_ready | input | 1 | Result consumer ready |
| resp_code | output | 3 | 0 ok, 1 root absent, 2 context absent, 3 page entry invalid, 4 address too wide, 5 unsupported context |
| resp_level | output | 3 | Leaf level on success, faulting level for code 3, else 0 |
| resp_paddr | output | 64 | Physical address (valid when code is 0) |
| resp_domain | output | 16 | Domain number from the context entry |
| resp_quiet | output | 1 | Fault-suppression hint from the context entry |

## Verification
On every cycle, the in-module assertions watch the handshake rules. They check that `req_ready` is low whenever a result is pending, that a stalled result and a stalled memory request hold steady, and that the fault codes agree with the level, domain and hint fields that go with them. Whether the right table words are fetched, and whether the leaf address is built correctly for 4 KiB, 2 MiB and 1 GiB mappings, can only be shown by the bench. Its sweep runs every combination of six requester IDs and sixteen addresses against a reference walk of the same memory image. It also compares the number of reads each request makes.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam int PG_SHIFT  = 12;
    localparam int HUGE_BIT  = 7;
    localparam int LVL_W     = 3;
    localparam logic [1:0] TT_MULTI = 2'd0;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ROOT   = 3'd1,
        ST_CTX_LO = 3'd2,
        ST_CTX_HI = 3'd3,
        ST_PTE    = 3'd4,
        ST_RESP   = 3'd5
    } walk_state_e;

    typedef enum logic [2:0] {
        XF_OK    = 3'd0,
        XF_ROOT  = 3'd1,
        XF_CTX   = 3'd2,
        XF_PTE   = 3'd3,
        XF_WIDTH = 3'd4,
        XF_CFG   = 3'd5
    } xlate_code_e;

    typedef struct packed {
        logic        ok;
        logic        quiet;
        logic [15:0] did;
        logic [63:0] pt_base;
    } ctx_info_t;

    typedef struct packed {
        logic        valid;
        logic        leaf;
        logic [63:0] next_base;
        logic [63:0] paddr;
    } pte_info_t;

    typedef struct packed {
        xlate_code_e      code;
        logic [LVL_W-1:0] level;
        logic [63:0]      paddr;
        logic [15:0]      did;
        logic             quiet;
    } xlate_result_t;

    function automatic logic [63:0] page_of(input logic [63:0] a);
        return {a[63:PG_SHIFT], {PG_SHIFT{1'b0}}};
    endfunction

    function automatic xlate_result_t make_result(
        input xlate_code_e      code,
        input logic [LVL_W-1:0] level,
        input logic [63:0]      paddr,
        input logic [15:0]      did,
        input logic             quiet
    );
        xlate_result_t r;
        r.code  = code;
        r.level = level;
        r.paddr = paddr;
        r.did   = did;
        r.quiet = quiet;
        return r;
    endfunction

endpackage

// File: rtl/xw_ctx_decode.sv
module xw_ctx_decode
    import xw_pkg::*;
#(
    parameter int IOVA_W   = 39,
    parameter int LVL_BITS = 9
) (
    input  logic [63:0] lo_word,
    input  logic [63:0] hi_word,
    output ctx_info_t   info
);
    // width code grows by one per extra 9-bit level above 30 bits
    localparam logic [2:0] AW_CODE = 3'((IOVA_W - 30) / LVL_BITS);

    always_comb begin
        info.ok      = (lo_word[3:2] == TT_MULTI) && (hi_word[2:0] == AW_CODE);
        info.quiet   = lo_word[1];
        info.did     = hi_word[23:8];
        info.pt_base = page_of(lo_word);
    end

    logic unused_bits;
    assign unused_bits = ^{lo_word[11:4], lo_word[0], hi_word[7:3], hi_word[63:24]};

endmodule

// File: rtl/xw_pte_eval.sv
module xw_pte_eval
    import xw_pkg::*;
#(
    parameter int IOVA_W   = 39,
    parameter int LVL_BITS = 9
) (
    input  logic [63:0]       pte,
    input  logic [IOVA_W-1:0] iova,
    input  logic [LVL_W-1:0]  level,
    output pte_info_t         info
);
    localparam int N_LVL = (IOVA_W - PG_SHIFT) / LVL_BITS;
    localparam int TOP_SH = PG_SHIFT + (N_LVL - 1) * LVL_BITS;

    logic [63:0] cand [1:N_LVL];

    for (genvar g = 1; g <= N_LVL; g++) begin : g_leaf
        localparam int SH = PG_SHIFT + (g - 1) * LVL_BITS;
        assign cand[g] = {pte[63:SH], iova[SH-1:0]};
    end

    always_comb begin
        info.valid     = |pte[1:0];
        info.leaf      = (level == LVL_W'(1)) || pte[HUGE_BIT];
        info.next_base = page_of(pte);
        info.paddr     = '0;
        for (int g = 1; g <= N_LVL; g++) begin
            if (level == LVL_W'(g)) info.paddr = cand[g];
        end
    end

    logic unused_bits;
    assign unused_bits = ^{iova[IOVA_W-1:TOP_SH]};

endmodule

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
    import xw_pkg::*;
#(
    parameter int IOVA_W   = 39,
    parameter int LVL_BITS = 9
) (
    input  walk_state_e       state,
    input  logic [63:0]       root_base,
    input  logic [15:0]       rid,
    input  logic [63:0]       tbl_base,
    input  logic [IOVA_W-1:0] iova,
    input  logic [LVL_W-1:0]  level,
    output logic [63:0]       addr
);
    localparam int N_LVL = (IOVA_W - PG_SHIFT) / LVL_BITS;

    logic [LVL_BITS-1:0] lvl_idx [1:N_LVL];
    logic [LVL_BITS-1:0] idx;

    for (genvar g = 1; g <= N_LVL; g++) begin : g_idx
        assign lvl_idx[g] = iova[PG_SHIFT + (g - 1) * LVL_BITS +: LVL_BITS];
    end

    always_comb begin
        idx = '0;
        for (int g = 1; g <= N_LVL; g++) begin
            if (level == LVL_W'(g)) idx = lvl_idx[g];
        end
    end

    logic [63:0] ctx_slot;
    assign ctx_slot = tbl_base + 64'({rid[7:0], 4'b0000});

    always_comb begin
        unique case (state)
            ST_ROOT:   addr = page_of(root_base) + 64'({rid[15:8], 4'b0000});
            ST_CTX_LO: addr = ctx_slot;
            ST_CTX_HI: addr = ctx_slot + 64'd8;
            ST_PTE:    addr = tbl_base + 64'({idx, 3'b000});
            default:   addr = '0;
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{root_base[PG_SHIFT-1:0], iova[PG_SHIFT-1:0]};

endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
    import xw_pkg::*;
#(
    parameter int IOVA_W   = 39,
    parameter int LVL_BITS = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       cfg_root_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [15:0]       req_rid,
    input  logic [63:0]       req_iova,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [63:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic [2:0]        resp_code,
    output logic [LVL_W-1:0]  resp_level,
    output logic [63:0]       resp_paddr,
    output logic [15:0]       resp_domain,
    output logic              resp_quiet
);
    localparam int N_LVL = (IOVA_W - PG_SHIFT) / LVL_BITS;

    walk_state_e       state_q, nxt_state;
    logic              pend_q, nxt_pend;
    logic [15:0]       rid_q, nxt_rid;
    logic [IOVA_W-1:0] iova_q, nxt_iova;
    logic [63:0]       tbl_q, nxt_tbl;
    logic [LVL_W-1:0]  lvl_q, nxt_lvl;
    logic [63:0]       lo_q, nxt_lo;
    logic [15:0]       did_q, nxt_did;
    xlate_result_t     res_q, nxt_res;
    logic              rv_q, nxt_rv;

    ctx_info_t ctx;
    pte_info_t pte;

    xw_ctx_decode #(.IOVA_W(IOVA_W), .LVL_BITS(LVL_BITS)) ctx_dec_i (
        .lo_word (lo_q),
        .hi_word (mem_rsp_data),
        .info    (ctx)
    );

    xw_pte_eval #(.IOVA_W(IOVA_W), .LVL_BITS(LVL_BITS)) pte_eval_i (
        .pte   (mem_rsp_data),
        .iova  (iova_q),
        .level (lvl_q),
        .info  (pte)
    );

    xw_addr_gen #(.IOVA_W(IOVA_W), .LVL_BITS(LVL_BITS)) addr_gen_i (
        .state     (state_q),
        .root_base (cfg_root_base),
        .rid       (rid_q),
        .tbl_base  (tbl_q),
        .iova      (iova_q),
        .level     (lvl_q),
        .addr      (mem_req_addr)
    );

    logic in_read;
    assign in_read = (state_q == ST_ROOT) || (state_q == ST_CTX_LO) ||
                     (state_q == ST_CTX_HI) || (state_q == ST_PTE);

    assign mem_req_valid = in_read && !pend_q;
    assign req_ready     = (state_q == ST_IDLE);

    always_comb begin
        nxt_state = state_q;
        nxt_pend  = pend_q;
        nxt_rid   = rid_q;
        nxt_iova  = iova_q;
        nxt_tbl   = tbl_q;
        nxt_lvl   = lvl_q;
        nxt_lo    = lo_q;
        nxt_did   = did_q;
        nxt_res   = res_q;
        nxt_rv    = rv_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_rid  = req_rid;
                    nxt_iova = req_iova[IOVA_W-1:0];
                    if (|req_iova[63:IOVA_W]) begin
                        nxt_res   = make_result(XF_WIDTH, '0, '0, '0, 1'b0);
                        nxt_rv    = 1'b1;
                        nxt_state = ST_RESP;
                    end else begin
                        nxt_state = ST_ROOT;
                    end
                end
            end
            ST_ROOT, ST_CTX_LO, ST_CTX_HI, ST_PTE: begin
                if (!pend_q && mem_req_ready) nxt_pend = 1'b1;
                if (pend_q && mem_rsp_valid) begin
                    nxt_pend = 1'b0;
                    unique case (state_q)
                        ST_ROOT: begin
                            if (!mem_rsp_data[0]) begin
                                nxt_res   = make_result(XF_ROOT, '0, '0, '0, 1'b0);
                                nxt_rv    = 1'b1;
                                nxt_state = ST_RESP;
                            end else begin
                                nxt_tbl   = page_of(mem_rsp_data);
                                nxt_state = ST_CTX_LO;
                            end
                        end
                        ST_CTX_LO: begin
                            if (!mem_rsp_data[0]) begin
                                nxt_res   = make_result(XF_CTX, '0, '0, '0, 1'b0);
                                nxt_rv    = 1'b1;
                                nxt_state = ST_RESP;
                            end else begin
                                nxt_lo    = mem_rsp_data;
                                nxt_state = ST_CTX_HI;
                            end
                        end
                        ST_CTX_HI: begin
                            nxt_did = ctx.did;
                            if (!ctx.ok) begin
                                nxt_res   = make_result(XF_CFG, '0, '0, ctx.did, ctx.quiet);
                                nxt_rv    = 1'b1;
                                nxt_state = ST_RESP;
                            end else begin
                                nxt_tbl   = ctx.pt_base;
                                nxt_lvl   = LVL_W'(N_LVL);
                                nxt_state = ST_PTE;
                            end
                        end
                        default: begin
                            if (!pte.valid) begin
                                nxt_res   = make_result(XF_PTE, lvl_q, '0, did_q, lo_q[1]);
                                nxt_rv    = 1'b1;
                                nxt_state = ST_RESP;
                            end else if (pte.leaf) begin
                                nxt_res   = make_result(XF_OK, lvl_q, pte.paddr, did_q, 1'b0);
                                nxt_rv    = 1'b1;
                                nxt_state = ST_RESP;
                            end else begin
                                nxt_tbl = pte.next_base;
                                nxt_lvl = lvl_q - LVL_W'(1);
                            end
                        end
                    endcase
                end
            end
            ST_RESP: begin
                if (resp_ready) begin
                    nxt_rv    = 1'b0;
                    nxt_state = ST_IDLE;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
            rid_q   <= '0;
            iova_q  <= '0;
            tbl_q   <= '0;
            lvl_q   <= '0;
            lo_q    <= '0;
            did_q   <= '0;
            res_q   <= make_result(XF_OK, '0, '0, '0, 1'b0);
            rv_q    <= 1'b0;
        end else begin
            state_q <= nxt_state;
            pend_q  <= nxt_pend;
            rid_q   <= nxt_rid;
            iova_q  <= nxt_iova;
            tbl_q   <= nxt_tbl;
            lvl_q   <= nxt_lvl;
            lo_q    <= nxt_lo;
            did_q   <= nxt_did;
            res_q   <= nxt_res;
            rv_q    <= nxt_rv;
        end
    end

    assign resp_valid  = rv_q;
    assign resp_code   = res_q.code;
    assign resp_level  = res_q.level;
    assign resp_paddr  = res_q.paddr;
    assign resp_domain = res_q.did;
    assign resp_quiet  = res_q.quiet;

    // R9: no new request may enter while a result is waiting
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !req_ready);

    // R9: a stalled result keeps every field
    a_r9_resp_hold: assert property (@(posedge clk) disable iff (rst)
        resp_valid && !resp_ready |=> resp_valid && $stable(resp_code) &&
        $stable(resp_level) && $stable(resp_paddr) && $stable(resp_domain) &&
        $stable(resp_quiet));

    // R4: an unaccepted memory request stays put
    a_r4_mem_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R8: no table read while the walker is idle
    a_r8_idle_no_read: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req_valid);

    // R5: an invalid page entry always names a level within the walk
    a_r5_pte_level: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_code == 3'd3 |-> resp_level != '0 && resp_level <= LVL_W'(N_LVL));

    // R6 / R7: a successful walk ends on a real level
    a_r7_ok_level: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_code == 3'd0 |-> resp_level != '0 && !resp_quiet);

    // R10 / R11: early faults carry no context fields
    a_r10_early_fault_clean: assert property (@(posedge clk) disable iff (rst)
        resp_valid && (resp_code == 3'd1 || resp_code == 3'd2 || resp_code == 3'd4) |->
        resp_level == '0 && resp_domain == '0 && !resp_quiet);

endmodule

// File: tb/dma_xlate_walker_tb_top.sv
module dma_xlate_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] cfg_root_base;
    logic        req_valid;
    logic        req_ready;
    logic [15:0] req_rid;
    logic [63:0] req_iova;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        resp_valid;
    logic        resp_ready;
    logic [2:0]  resp_code;
    logic [2:0]  resp_level;
    logic [63:0] resp_paddr;
    logic [15:0] resp_domain;
    logic        resp_quiet;

    always #2 clk = ~clk;

    dma_xlate_walker dut_i (
        .clk, .rst, .cfg_root_base,
        .req_valid, .req_ready, .req_rid, .req_iova,
        .mem_req_valid, .mem_req_ready, .mem_req_addr,
        .mem_rsp_valid, .mem_rsp_data,
        .resp_valid, .resp_ready, .resp_code, .resp_level,
        .resp_paddr, .resp_domain, .resp_quiet
    );

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int cyc    = 0;

    logic [63:0] mem [0:4095];

    function automatic logic [63:0] rdm(input logic [63:0] a);
        if (a < 64'h8000) return mem[a[14:3]];
        return 64'd0;
    endfunction

    function automatic logic [63:0] pg(input logic [63:0] a);
        return {a[63:12], 12'h000};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // reference walk written from the requirement text
    function automatic void ref_walk(
        input  logic [15:0] rid, input logic [63:0] iova, input logic [63:0] base,
        output logic [2:0] code, output logic [2:0] lvl, output logic [63:0] pa,
        output logic [15:0] did, output logic quiet, output int nrd);
        logic [63:0] re, lo, hi, tbl, pte, msk;
        logic [63:0] ix;
        code = 0; lvl = 0; pa = 0; did = 0; quiet = 0; nrd = 0;
        if (iova[63:39] != 0) begin code = 4; return; end
        re = rdm(pg(base) + 64'(rid[15:8]) * 16); nrd = 1;
        if (!re[0]) begin code = 1; return; end
        lo = rdm(pg(re) + 64'(rid[7:0]) * 16); nrd = 2;
        if (!lo[0]) begin code = 2; return; end
        hi = rdm(pg(re) + 64'(rid[7:0]) * 16 + 8); nrd = 3;
        did = hi[23:8];
        if (lo[3:2] != 2'd0 || hi[2:0] != 3'd1) begin code = 5; quiet = lo[1]; return; end
        tbl = pg(lo);
        for (int l = 3; l >= 1; l--) begin
            ix  = (iova >> (12 + 9 * (l - 1))) & 64'h1FF;
            pte = rdm(tbl + ix * 8); nrd++;
            if (pte[1:0] == 2'b00) begin code = 3; lvl = 3'(l); quiet = lo[1]; return; end
            if (l == 1 || pte[7]) begin
                msk = (64'd1 << (12 + 9 * (l - 1))) - 1;
                pa  = (pte & ~msk) | (iova & msk);
                lvl = 3'(l);
                return;
            end
            tbl = pg(pte);
        end
    endfunction

    function automatic string tag_of(input logic [2:0] code, input logic [2:0] lvl);
        case (code)
            3'd0: return (lvl == 3'd1) ? "R6" : "R7";
            3'd1: return "R1";
            3'd2: return "R2";
            3'd3: return "R5";
            3'd4: return "R8";
            default: return "R3";
        endcase
    endfunction

    // memory responder: irregular ready, one or two cycles of latency
    initial begin
        logic        busy;
        logic [63:0] p_addr;
        int          dly;
        busy = 1'b0; p_addr = '0; dly = 0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            if (busy) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rdm(p_addr);
                    busy = 1'b0;
                end else dly--;
            end
            mem_req_ready = ((cyc % 3) != 0) && !busy;
            if (mem_req_valid && mem_req_ready) begin
                busy   = 1'b1;
                p_addr = mem_req_addr;
                dly    = cyc % 2;
                rd_cnt++;
            end
        end
    end

    task automatic run_one(input logic [15:0] rid, input logic [63:0] iova,
                           input logic [63:0] base, input int stall);
        logic [2:0]  e_code, e_lvl;
        logic [63:0] e_pa;
        logic [15:0] e_did;
        logic        e_q;
        int          e_nrd, n;
        logic [63:0] s_pa;
        logic [2:0]  s_code;
        string       t;
        ref_walk(rid, iova, base, e_code, e_lvl, e_pa, e_did, e_q, e_nrd);
        t = tag_of(e_code, e_lvl);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cfg_root_base = base;
        rd_cnt    = 0;
        req_valid = 1'b1; req_rid = rid; req_iova = iova;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!resp_valid && n < 300) begin @(negedge clk); n++; end
        if (!resp_valid) begin
            chk(t, "no response", 64'd0, 64'd1);
            return;
        end
        if (stall > 0) begin
            s_pa = resp_paddr; s_code = resp_code;
            repeat (stall) @(negedge clk);
            chk("R9", "ready while result pending", 64'(req_ready), 64'd0);
            chk("R9", "held code", 64'(resp_code), 64'(s_code));
            chk("R9", "held paddr", resp_paddr, s_pa);
        end
        chk(t, "code", 64'(resp_code), 64'(e_code));
        chk(t, "level", 64'(resp_level), 64'(e_lvl));
        if (e_code == 3'd0) chk(t, "paddr", resp_paddr, e_pa);
        chk("R10", "domain", 64'(resp_domain), 64'(e_did));
        chk("R11", "quiet", 64'(resp_quiet), 64'(e_q));
        chk((e_code == 3'd4) ? "R8" : "R4", "read count", 64'(rd_cnt), 64'(e_nrd));
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        chk("R9", "ready after handshake", 64'(req_ready), 64'd1);
        chk("R9", "valid drops after handshake", 64'(resp_valid), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    logic [15:0] rids [0:5];
    logic [63:0] iovas [0:15];

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 64'd0;
        // root: bus 1 present, bus 0 absent
        mem[(64'h1010) >> 3] = 64'h2001;
        // context entries in the bus-1 table
        mem[(64'h2000 + 16*8'h10) >> 3]     = 64'h3003;
        mem[(64'h2000 + 16*8'h10 + 8) >> 3] = (64'hABCD << 8) | 64'd1;
        mem[(64'h2000 + 16*8'h11) >> 3]     = 64'h3001;
        mem[(64'h2000 + 16*8'h11 + 8) >> 3] = (64'h0011 << 8) | 64'd2;
        mem[(64'h2000 + 16*8'h12) >> 3]     = 64'h3007;
        mem[(64'h2000 + 16*8'h12 + 8) >> 3] = (64'h0012 << 8) | 64'd1;
        mem[(64'h2000 + 16*8'h14) >> 3]     = 64'h3001;
        mem[(64'h2000 + 16*8'h14 + 8) >> 3] = (64'h0014 << 8) | 64'd1;
        // level 3 table
        mem[(64'h3000 + 0*8) >> 3] = 64'h4003;
        mem[(64'h3000 + 1*8) >> 3] = 64'h4000_0083;
        mem[(64'h3000 + 3*8) >> 3] = 64'h5001;
        // level 2 table
        mem[(64'h4000 + 0*8) >> 3] = 64'h6003;
        mem[(64'h4000 + 1*8) >> 3] = 64'h00A0_0082;
        // level 1 table, entries 0..7 valid
        for (int k = 0; k < 8; k++)
            mem[(64'h6000 + 64'(k)*8) >> 3] = (64'h10_0000 + 64'(k) * 64'h1000) | ((k % 2 == 1) ? 64'd3 : 64'd1);

        rids[0] = 16'h0010; rids[1] = 16'h0110; rids[2] = 16'h0111;
        rids[3] = 16'h0112; rids[4] = 16'h0113; rids[5] = 16'h0114;
        for (int k = 0; k < 9; k++) iovas[k] = 64'(k) * 64'h1000 + 64'(k) * 64'h10 + 64'h8;
        iovas[9]  = 64'h0021_ABCD;
        iovas[10] = 64'h0040_0000;
        iovas[11] = 64'h4001_2345;
        iovas[12] = 64'h8000_0000;
        iovas[13] = 64'hC000_0000;
        iovas[14] = (64'd1 << 39) | 64'h1000;
        iovas[15] = 64'd1 << 63;

        rst = 1'b1; cfg_root_base = 64'h1000;
        req_valid = 1'b0; req_rid = '0; req_iova = '0; resp_ready = 1'b0;
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "reset ready", 64'(req_ready), 64'd1);
        chk("R9", "reset resp_valid", 64'(resp_valid), 64'd0);
        chk("R8", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);

        // full sweep of requesters and addresses
        for (int r = 0; r < 6; r++)
            for (int a = 0; a < 16; a++)
                run_one(rids[r], iovas[a], 64'h1000, 0);

        // R1: low bits of the root base have no effect
        run_one(16'h0110, 64'h3038, 64'h1FF8, 0);
        run_one(16'h0010, 64'h3038, 64'h1ABC, 0);
        // R9: stalled results across several outcomes
        run_one(16'h0110, 64'h0021_ABCD, 64'h1000, 3);
        run_one(16'h0112, 64'h1000, 64'h1000, 2);
        run_one(16'h0114, 64'h8000_0000, 64'h1000, 4);
        run_one(16'h0110, (64'd1 << 40), 64'h1000, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule